// File: doc/BRIEF.md
# Flash Sector Lock and Identification Unit

This block keeps one lock bit for each of the 134 erase sectors of a 4M-word flash array and answers identification reads. The sector map is not uniform: the lowest 32K words and the highest 32K words are each split into four small 8K-word boot sectors. Everything in between is divided into 126 sectors of 32K words. A shared decoder turns any 22-bit word address into a sector index. Three copies of that decoder serve the three address inputs.

The command sequencer feeds the block three things: single-cycle lock/unlock events, the state of the write-protect pin, and identification read requests. The program/erase engine presents the address it is about to modify on the access port. It receives a combinational protected flag in the same cycle, which it uses to block the operation. During a whole-array erase the engine steps through the sectors and gets the flag for each one in turn. Identification reads return fixed manufacturer and device codes, or the lock status of the addressed sector. Every lock bit comes out of power-on reset in the locked state.

Top module: `sector_guard`

## Requirements
- R1: Word addresses 000000h to 007FFFh map to sectors 0 to 3, each covering 2000h words, in ascending order.
- R2: Word addresses 008000h to 3F7FFFh map to sectors 4 to 129, each covering 8000h words; the sector index is address bits 21..15 plus 3.
- R3: Word addresses 3F8000h to 3FFFFFh map to sectors 130 to 133, each covering 2000h words, in ascending order.
- R4: After reset every sector is locked, so `accProt` is 1 at every address.
- R5: A cycle with `lockEn` high writes the lock bit of the sector that contains `lockAddr`. `lockAddr` bit 6 = 0 locks the sector and bit 6 = 1 unlocks it. The new value shows on `accProt` from the cycle after the clock edge, and no other sector changes.
- R6: While `wpN` is 0, `accProt` is 1 whatever the lock bits hold. The lock bits are kept, and they govern `accProt` again once `wpN` returns to 1.
- R7: `accProt` depends combinationally on `accAddr`, `wpN` and the current lock bits, with no clock delay.
- R8: `idData` is loaded at the clock edge where `idReq` is 1 and holds its value otherwise; it is 0000h after reset. An `idAddr[7:0]` of 00h loads 0004h, and 01h loads 227Eh.
- R9: An `idAddr[7:0]` of 0Eh loads 2224h, and 0Fh loads 2201h.
- R10: An `idAddr[7:0]` of 02h loads 0001h if the sector that contains `idAddr` is locked and 0000h if it is unlocked. `wpN` does not affect this value.
- R11: Any other value of `idAddr[7:0]` loads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| accAddr | input | 22 | Word address of the program/erase access being checked |
| wpN | input | 1 | Write-protect pin, low protects every sector |
| accProt | output | 1 | Access at accAddr is protected |
| lockEn | input | 1 | Lock/unlock event strobe |
| lockAddr | input | 22 | Sector address of the event; bit 6 selects unlock (1) or lock (0) |
| idReq | input | 1 | Identification read request |
| idAddr | input | 22 | Identification address; bits 7..0 select the code, upper bits the sector |
| idData | output | 16 | Registered identification data |

## Verification
The clocked properties assume that `lockEn` and `idReq` are sampled at the rising edge and mean one event per cycle. They also assume that a lock effect is judged only when `accAddr` stays put across the following edge. The bench changes every input half a period away from the rising edge. Each lock event and each identification request lasts one cycle. Random access addresses are drawn fresh every cycle, so only cycles where the address is stable can meet the lock-visibility antecedents. Write-protect is toggled at random between operations, and this exercises the override and the retention of the lock bits underneath it.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [2:0] {
    ID_NONE,
    ID_MFR,
    ID_DEV,
    ID_EXT_HI,
    ID_EXT_LO,
    ID_LOCK
  } idKind_e;

  typedef struct packed {
    logic    lockWr;
    logic    lockVal;
    logic    idLoad;
    idKind_e idKind;
  } sgStrobe_t;

  localparam logic [15:0] MFR_CODE    = 16'h0004;
  localparam logic [15:0] DEV_CODE    = 16'h227E;
  localparam logic [15:0] EXT_HI_CODE = 16'h2224;
  localparam logic [15:0] EXT_LO_CODE = 16'h2201;

  localparam logic [7:0] OFS_MFR    = 8'h00;
  localparam logic [7:0] OFS_DEV    = 8'h01;
  localparam logic [7:0] OFS_LOCK   = 8'h02;
  localparam logic [7:0] OFS_EXT_HI = 8'h0E;
  localparam logic [7:0] OFS_EXT_LO = 8'h0F;

endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map #(
  parameter int ADDR_W    = 22,
  parameter int BIG_LSB   = 15,
  parameter int SMALL_LSB = 13,
  parameter int SEC_W     = 8
) (
  input  logic [ADDR_W-1:SMALL_LSB] addrHi,
  output logic [SEC_W-1:0]          secIdx
);
  localparam int BOOT_CNT = 1 << (BIG_LSB - SMALL_LSB);
  localparam int BIG_CNT  = (1 << (ADDR_W - BIG_LSB)) - 2;
  localparam int SECTORS  = BIG_CNT + 2 * BOOT_CNT;

  logic [ADDR_W-BIG_LSB-1:0]    bigField;
  logic [BIG_LSB-SMALL_LSB-1:0] smallField;

  assign bigField   = addrHi[ADDR_W-1:BIG_LSB];
  assign smallField = addrHi[BIG_LSB-1:SMALL_LSB];

  always_comb begin
    if (bigField == '0)
      secIdx = SEC_W'(smallField);
    else if (bigField == '1)
      secIdx = SEC_W'(BOOT_CNT + BIG_CNT) + SEC_W'(smallField);
    else
      secIdx = SEC_W'(bigField) + SEC_W'(BOOT_CNT - 1);
  end

  // R1 R2 R3: every address lands on an existing sector
  always_comb begin
    if (!$isunknown(addrHi))
      a_idx_range_r2: assert (int'(secIdx) < SECTORS);
  end

endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             lockEn,
  input  logic             lockSel,
  input  logic             idReq,
  input  logic [OFS_W-1:0] idOfs,
  output sgStrobe_t        strobe
);

  always_comb begin
    strobe.lockWr  = lockEn;
    strobe.lockVal = ~lockSel;
    strobe.idLoad  = idReq;
    case (idOfs)
      OFS_W'(OFS_MFR):    strobe.idKind = ID_MFR;
      OFS_W'(OFS_DEV):    strobe.idKind = ID_DEV;
      OFS_W'(OFS_LOCK):   strobe.idKind = ID_LOCK;
      OFS_W'(OFS_EXT_HI): strobe.idKind = ID_EXT_HI;
      OFS_W'(OFS_EXT_LO): strobe.idKind = ID_EXT_LO;
      default:            strobe.idKind = ID_NONE;
    endcase
  end

endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int SECTORS = 134,
  parameter int SEC_W   = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  sgStrobe_t         strobe,
  input  logic [SEC_W-1:0]  accSec,
  input  logic [SEC_W-1:0]  lockSec,
  input  logic [SEC_W-1:0]  idSec,
  output logic              accProt,
  output logic [DATA_W-1:0] idData
);

  logic [SECTORS-1:0] lockBits;
  logic [DATA_W-1:0]  idNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lockBits <= '1;
    else if (strobe.lockWr)
      lockBits[lockSec] <= strobe.lockVal;
  end

  assign accProt = ~wpN | lockBits[accSec];

  always_comb begin
    case (strobe.idKind)
      ID_MFR:    idNext = DATA_W'(MFR_CODE);
      ID_DEV:    idNext = DATA_W'(DEV_CODE);
      ID_EXT_HI: idNext = DATA_W'(EXT_HI_CODE);
      ID_EXT_LO: idNext = DATA_W'(EXT_LO_CODE);
      ID_LOCK:   idNext = DATA_W'(lockBits[idSec]);
      default:   idNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idData <= '0;
    else if (strobe.idLoad)
      idData <= idNext;
  end

  p_lock_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockWr |=> lockBits[$past(lockSec)] == $past(strobe.lockVal));

  p_id_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.idLoad |=> $stable(idData));

  p_status_bit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.idLoad && strobe.idKind == ID_LOCK) |=> idData[DATA_W-1:1] == '0);

endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W       = 22,
  parameter int BIG_LSB      = 15,
  parameter int SMALL_LSB    = 13,
  parameter int OFS_W        = 8,
  parameter int DATA_W       = 16,
  parameter int LOCK_SEL_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              wpN,
  output logic              accProt,
  input  logic              lockEn,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic              idReq,
  input  logic [ADDR_W-1:0] idAddr,
  output logic [DATA_W-1:0] idData
);
  import sg_pkg::*;

  localparam int BOOT_CNT = 1 << (BIG_LSB - SMALL_LSB);
  localparam int BIG_CNT  = (1 << (ADDR_W - BIG_LSB)) - 2;
  localparam int SECTORS  = BIG_CNT + 2 * BOOT_CNT;
  localparam int SEC_W    = $clog2(SECTORS);
  localparam int N_PORTS  = 3;

  logic [ADDR_W-1:SMALL_LSB] mapIn  [N_PORTS];
  logic [SEC_W-1:0]          mapOut [N_PORTS];
  sgStrobe_t                 strobe;
  logic                      unusedLowBits;

  assign mapIn[0] = accAddr[ADDR_W-1:SMALL_LSB];
  assign mapIn[1] = lockAddr[ADDR_W-1:SMALL_LSB];
  assign mapIn[2] = idAddr[ADDR_W-1:SMALL_LSB];
  assign unusedLowBits = ^{accAddr[SMALL_LSB-1:0], lockAddr[SMALL_LSB-1:0],
                           idAddr[SMALL_LSB-1:OFS_W]};

  for (genvar i = 0; i < N_PORTS; i++) begin : g_map
    sg_sector_map #(
      .ADDR_W(ADDR_W), .BIG_LSB(BIG_LSB), .SMALL_LSB(SMALL_LSB), .SEC_W(SEC_W)
    ) u_map (
      .addrHi(mapIn[i]),
      .secIdx(mapOut[i])
    );
  end

  sg_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .lockEn (lockEn),
    .lockSel(lockAddr[LOCK_SEL_BIT]),
    .idReq  (idReq),
    .idOfs  (idAddr[OFS_W-1:0]),
    .strobe (strobe)
  );

  sg_datapath #(.SECTORS(SECTORS), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wpN    (wpN),
    .strobe (strobe),
    .accSec (mapOut[0]),
    .lockSec(mapOut[1]),
    .idSec  (mapOut[2]),
    .accProt(accProt),
    .idData (idData)
  );

  p_wp_forces_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |-> accProt);

  p_lock_visible_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockEn && !lockAddr[LOCK_SEL_BIT] &&
     accAddr[ADDR_W-1:SMALL_LSB] == lockAddr[ADDR_W-1:SMALL_LSB])
    ##1 $stable(accAddr) |-> accProt);

  p_unlock_visible_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockEn && lockAddr[LOCK_SEL_BIT] &&
     accAddr[ADDR_W-1:SMALL_LSB] == lockAddr[ADDR_W-1:SMALL_LSB])
    ##1 ($stable(accAddr) && wpN) |-> !accProt);

  p_mfr_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idReq && idAddr[OFS_W-1:0] == OFS_W'(OFS_MFR)) |=> idData == DATA_W'(MFR_CODE));

  p_ext_lo_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idReq && idAddr[OFS_W-1:0] == OFS_W'(OFS_EXT_LO)) |=> idData == DATA_W'(EXT_LO_CODE));

endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] accAddr = '0;
  logic        wpN = 1'b1;
  logic        accProt;
  logic        lockEn = 1'b0;
  logic [21:0] lockAddr = '0;
  logic        idReq = 1'b0;
  logic [21:0] idAddr = '0;
  logic [15:0] idData;

  int  nChk = 0;
  int  nBad = 0;
  bit  model [134];
  bit  finished = 1'b0;
  logic [15:0] lastId = '0;

  always #2 clk = ~clk;

  sector_guard u_dut (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .wpN(wpN), .accProt(accProt),
    .lockEn(lockEn), .lockAddr(lockAddr), .idReq(idReq), .idAddr(idAddr),
    .idData(idData)
  );

  function automatic int sectorOf(logic [21:0] a);
    if (a < 22'h008000)       return int'(a >> 13);
    else if (a >= 22'h3F8000) return 130 + int'((a - 22'h3F8000) >> 13);
    else                      return 4 + int'((a - 22'h008000) >> 15);
  endfunction

  function automatic logic [21:0] sectorStart(int s);
    if (s < 4)        return 22'(s * 32'h2000);
    else if (s < 130) return 22'(32'h8000 + (s - 4) * 32'h8000);
    else              return 22'(32'h3F8000 + (s - 130) * 32'h2000);
  endfunction

  function automatic string regionReq(int s);
    if (s < 4)        return "R1";
    else if (s < 130) return "R2";
    else              return "R3";
  endfunction

  function automatic logic [15:0] idExp(logic [21:0] a);
    case (a[7:0])
      8'h00:   return 16'h0004;
      8'h01:   return 16'h227E;
      8'h0E:   return 16'h2224;
      8'h0F:   return 16'h2201;
      8'h02:   return {15'b0, model[sectorOf(a)]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // combinational probe, R7: no clock edge between drive and sample
  task automatic probe(logic [21:0] a, string req);
    accAddr = a;
    #0.5;
    chk(req, {15'b0, accProt}, {15'b0, (!wpN) | model[sectorOf(a)]});
  endtask

  task automatic lockOp(logic [21:0] a, bit unlock);
    lockEn   = 1'b1;
    lockAddr = {a[21:7], unlock, a[5:0]};
    @(posedge clk);
    model[sectorOf(lockAddr)] = !unlock;
    @(negedge clk);
    lockEn = 1'b0;
  endtask

  task automatic idRead(logic [21:0] a, string req);
    logic [15:0] e;
    idReq  = 1'b1;
    idAddr = a;
    e = idExp(a);
    @(posedge clk);
    @(negedge clk);
    idReq = 1'b0;
    chk(req, idData, e);
    lastId = e;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    for (int s = 0; s < 134; s++) model[s] = 1'b1;
    seedVal = $urandom(32'h5EC7);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 and R8 reset state
    chk("R8 reset idData", idData, 16'h0000);
    for (int s = 0; s < 134; s++) probe(sectorStart(s), "R4 locked after reset");
    probe(22'h3FFFFF, "R4 locked after reset top");

    // R1 R2 R3 R5: every boundary and its neighbours
    lockOp(22'h000000, 1'b1);
    probe(22'h000000, "R1 sector 0 unlocked");
    probe(22'h001FFF, "R1 sector 0 end");
    probe(22'h002000, "R1 sector 1 still locked");
    lockOp(22'h000000, 1'b0);
    for (int s = 1; s < 134; s++) begin
      logic [21:0] b;
      logic [21:0] e;
      b = sectorStart(s);
      e = (s == 133) ? 22'h3FFFFF : sectorStart(s + 1) - 22'd1;
      lockOp(b, 1'b1);
      probe(b,         {regionReq(s), " boundary start unlocked"});
      probe(e,         {regionReq(s), " sector end unlocked"});
      probe(b - 22'd1, {regionReq(s), " lower neighbour locked R5"});
      if (s < 133) probe(e + 22'd1, {regionReq(s), " upper neighbour locked R5"});
      lockOp(b, 1'b0);
      probe(b, "R5 relocked");
    end

    // R6 write protect override and retention; R10 unaffected by wp
    lockOp(22'h050123, 1'b1);
    probe(22'h050000, "R6 unlocked before wp");
    wpN = 1'b0;
    probe(22'h050000, "R6 wp forces protect");
    probe(22'h000000, "R6 wp on locked");
    idRead(22'h051002, "R10 status ignores wp");
    wpN = 1'b1;
    probe(22'h057FFF, "R6 lock bits retained");

    // R8 R9 R10 R11 directed identification reads
    idRead(22'h300000, "R8 manufacturer code");
    idRead(22'h100001, "R8 device code");
    @(posedge clk); @(negedge clk);
    chk("R8 hold without request", idData, lastId);
    idRead(22'h20000E, "R9 extended code high");
    idRead(22'h00000F, "R9 extended code low");
    idRead(22'h3FE002, "R10 locked top boot sector");
    idRead(22'h050002, "R10 unlocked sector");
    idRead(22'h000003, "R11 undefined offset");
    idRead(22'h0000FF, "R11 undefined offset high");
    lockOp(22'h3FE000, 1'b1);
    idRead(22'h3FE002, "R10 after unlock");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [21:0] ra;
      int op;
      ra = 22'($urandom);
      op = $urandom_range(0, 3);
      case (op)
        0: lockOp(ra, 1'($urandom_range(0, 1)));
        1: begin
          logic [7:0] ofs;
          case ($urandom_range(0, 5))
            0: ofs = 8'h00; 1: ofs = 8'h01; 2: ofs = 8'h02;
            3: ofs = 8'h0E; 4: ofs = 8'h0F; default: ofs = 8'($urandom);
          endcase
          idRead({ra[21:8], ofs}, "R8 R9 R10 R11 random id read");
        end
        2: begin
          wpN = ($urandom_range(0, 3) != 0);
          probe(ra, "R6 random protect");
          @(negedge clk);
        end
        default: begin
          probe(ra, "R5 random protect");
          @(negedge clk);
        end
      endcase
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule